// File: doc/BRIEF.md
# Serial Camera Line Byte Deserializer

This block turns a one-bit serial camera stream into 8-bit parallel words. Two digital lines reach it from an oversampling front end that has already brought them into the system clock domain: a data line and an auxiliary line. A run-time class input selects how the auxiliary line is read. In strobe signalling, the auxiliary line is a strobe. A new bit is present whenever the exclusive-OR of data and strobe changes. In clock signalling, the auxiliary line is a bit clock, and data is captured only on its rising edges.

Recovered bits are shifted most-significant bit first into a partial word. After the eighth bit, the finished word is presented on a parallel bus. The block then raises a single-cycle valid pulse and starts a word clock that stays high for a fixed number of cycles. A downstream framer that has found a sync code can pulse the alignment input to restart byte framing. Dropping the enable input puts the block into a quiet state: framing is cleared, and no output toggles.

Top module: `strobe_byte_deser`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, word_out is 0 and word_valid and word_clk are low.
- R2: With class_hi = 1 (strobe signalling), a bit is taken in each cycle where ser_data XOR ser_aux differs from its value in the previous cycle. The bit's value is ser_data in that cycle. Holding both lines steady adds no bits.
- R3: With class_hi = 0 (clock signalling), a bit is taken only in a cycle where ser_aux is 1 and was 0 in the previous cycle. The bit's value is ser_data in that cycle. Falling edges of ser_aux, and data changes without a rising edge, add no bits.
- R4: Bits are assembled most-significant first: the first bit of a word appears at word_out[7] and the eighth bit at word_out[0].
- R5: Suppose the input sample carrying the eighth bit of a word is present before clock edge k. Then word_out takes the new word at edge k+1, and word_valid is high for exactly that one cycle.
- R6: While enabled, word_out keeps its value between word completions.
- R7: word_clk rises in the same cycle as word_valid and stays high for HOLD_CYC cycles (default 4). It is low at all other times.
- R8: When align is high at a clock edge, the bit count and partial word are cleared, and any bit pending at that edge is discarded. The next eight bits then form a complete word.
- R9: While enable is low, the bit count, partial word and word_out are cleared, word_valid and word_clk stay low, and line activity adds no bits.
- R10: class_hi is read every cycle, so a single word may be assembled from bits received partly in strobe signalling and partly in clock signalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low gives the quiet, cleared state |
| class_hi | input | 1 | 1 = strobe signalling, 0 = clock signalling |
| align | input | 1 | Restart byte framing |
| ser_data | input | 1 | Synchronised serial data line |
| ser_aux | input | 1 | Synchronised strobe or bit clock line |
| word_out | output | 8 | Last assembled parallel word |
| word_valid | output | 1 | One-cycle pulse when word_out is updated |
| word_clk | output | 1 | Word clock accompanying word_out |

## Verification
The bound checker watches properties that must hold in every cycle. word_valid is never high for two cycles in a row. word_clk can only rise together with word_valid. word_out is stable between completions. A cycle with align high, or with enable low, is never followed by a valid word. Only the bench scenarios can show that bits are recovered correctly from strobe transitions and from rising clock edges, and that the MSB-first ordering is right. The same holds for the discarding of a partial word on alignment, for the suppression of line activity while disabled, and for a word built across a change of signalling class. For these, the bench compares against its behavioural model every cycle and checks each expected byte.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    typedef enum logic {
        LINE_CLOCK  = 1'b0,
        LINE_STROBE = 1'b1
    } line_mode_e;

    typedef struct packed {
        logic valid;
        logic value;
    } bit_evt_t;

    // A strobe-signalled bit exists whenever data^strobe changes.
    function automatic logic strobe_bit_seen(input logic d, input logic s,
                                             input logic pd, input logic ps);
        return (d ^ s) != (pd ^ ps);
    endfunction

    // A clock-signalled bit exists only on a rising edge of the clock line.
    function automatic logic clock_bit_seen(input logic s, input logic ps);
        return s & ~ps;
    endfunction

endpackage

// File: rtl/sdr_bit_recover.sv
module sdr_bit_recover
    import sdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  line_mode_e mode,
    input  logic       ser_data,
    input  logic       ser_aux,
    output bit_evt_t   evt_q
);

    logic     prev_data;
    logic     prev_aux;
    bit_evt_t evt_d;

    always_comb begin
        evt_d.value = ser_data;
        case (mode)
            LINE_STROBE: evt_d.valid = strobe_bit_seen(ser_data, ser_aux, prev_data, prev_aux);
            default:     evt_d.valid = clock_bit_seen(ser_aux, prev_aux);
        endcase
        evt_d.valid = evt_d.valid & enable;
    end

    // Line history is tracked in every cycle so that re-enabling or
    // switching class does not invent an edge from stale history.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_data <= 1'b0;
            prev_aux  <= 1'b0;
            evt_q     <= '0;
        end else begin
            prev_data <= ser_data;
            prev_aux  <= ser_aux;
            evt_q     <= evt_d;
        end
    end

endmodule

// File: rtl/sdr_word_asm.sv
module sdr_word_asm
    import sdr_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              align,
    input  bit_evt_t          evt,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid,
    output logic              word_fire
);

    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] shreg_next;
    logic [CNT_W-1:0]  bit_cnt;
    logic              at_last;

    assign at_last    = (bit_cnt == LAST_IDX);
    assign shreg_next = {shreg[WORD_W-2:0], evt.value};
    // Alignment wins over a bit pending at the same edge.
    assign word_fire  = enable & ~align & evt.valid & at_last;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            shreg      <= '0;
            bit_cnt    <= '0;
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= word_fire;
            if (align) begin
                shreg   <= '0;
                bit_cnt <= '0;
            end else if (evt.valid) begin
                shreg <= shreg_next;
                if (at_last) begin
                    bit_cnt  <= '0;
                    word_out <= shreg_next;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sdr_word_clk.sv
module sdr_word_clk #(
    parameter int HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic word_fire,
    output logic word_clk
);

    generate
        if (HOLD_CYC == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst || !enable) word_clk <= 1'b0;
                else                word_clk <= word_fire;
            end
        end else begin : g_counted
            localparam int HC_W = $clog2(HOLD_CYC);
            logic [HC_W-1:0] hold_left;

            always_ff @(posedge clk) begin
                if (rst || !enable) begin
                    word_clk  <= 1'b0;
                    hold_left <= '0;
                end else if (word_fire) begin
                    word_clk  <= 1'b1;
                    hold_left <= HC_W'(HOLD_CYC - 1);
                end else if (hold_left != '0) begin
                    hold_left <= hold_left - 1'b1;
                end else begin
                    word_clk <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/strobe_byte_deser.sv
module strobe_byte_deser
    import sdr_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int HOLD_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              class_hi,
    input  logic              align,
    input  logic              ser_data,
    input  logic              ser_aux,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid,
    output logic              word_clk
);

    generate
        if (HOLD_CYC < 1 || HOLD_CYC >= WORD_W) begin : g_bad_hold
            $error("HOLD_CYC must lie in 1..WORD_W-1");
        end
        if (WORD_W < 2) begin : g_bad_width
            $error("WORD_W must be at least 2");
        end
    endgenerate

    line_mode_e mode;
    bit_evt_t   evt;
    logic       word_fire;

    assign mode = line_mode_e'(class_hi);

    sdr_bit_recover u_recover (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .mode     (mode),
        .ser_data (ser_data),
        .ser_aux  (ser_aux),
        .evt_q    (evt)
    );

    sdr_word_asm #(.WORD_W(WORD_W)) u_asm (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .align      (align),
        .evt        (evt),
        .word_out   (word_out),
        .word_valid (word_valid),
        .word_fire  (word_fire)
    );

    sdr_word_clk #(.HOLD_CYC(HOLD_CYC)) u_wclk (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .word_fire (word_fire),
        .word_clk  (word_clk)
    );

endmodule

// File: rtl/sdr_deser_chk.sv
module sdr_deser_chk (
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic       align,
    input logic [7:0] word_out,
    input logic       word_valid,
    input logic       word_clk
);

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid); // R5

    AST_WCLK_RISE_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        $rose(word_clk) |-> word_valid); // R7

    AST_VALID_HAS_WCLK: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> word_clk); // R7

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && !word_valid) |-> $stable(word_out)); // R6

    AST_ALIGN_NO_WORD: assert property (@(posedge clk) disable iff (rst)
        align |=> !word_valid); // R8

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!word_valid && !word_clk && word_out == 8'h00)); // R9

endmodule

bind strobe_byte_deser sdr_deser_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .align      (align),
    .word_out   (word_out),
    .word_valid (word_valid),
    .word_clk   (word_clk)
);

// File: tb/strobe_byte_deser_tb.sv
`timescale 1ns/1ps
module strobe_byte_deser_tb;

    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       class_hi = 1'b1;
    logic       align = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_aux = 1'b0;
    logic [7:0] word_out;
    logic       word_valid;
    logic       word_clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    strobe_byte_deser u_dut (
        .clk(clk), .rst(rst), .enable(enable), .class_hi(class_hi), .align(align),
        .ser_data(ser_data), .ser_aux(ser_aux),
        .word_out(word_out), .word_valid(word_valid), .word_clk(word_clk)
    );

    // Behavioural reference model, advanced at each rising edge.
    int  m_cnt = 0, m_sh = 0, m_word = 0, m_hold = 0;
    bit  m_valid = 0, m_wclk = 0, m_fire;
    bit  p_evt = 0, p_bit = 0, pd = 0, ps = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_sh = 0; m_word = 0; m_hold = 0;
            m_valid = 0; m_wclk = 0; p_evt = 0; p_bit = 0; pd = 0; ps = 0;
        end else begin
            m_fire = 0;
            if (!enable) begin
                m_cnt = 0; m_sh = 0; m_word = 0; m_valid = 0; m_wclk = 0; m_hold = 0;
            end else begin
                m_valid = 0;
                if (align) begin
                    m_cnt = 0; m_sh = 0;
                end else if (p_evt) begin
                    m_sh = ((m_sh << 1) | int'(p_bit)) & 8'hFF;
                    m_cnt++;
                    if (m_cnt == 8) begin
                        m_word = m_sh; m_valid = 1; m_cnt = 0; m_fire = 1;
                    end
                end
                if (m_fire) begin m_wclk = 1; m_hold = HOLD - 1; end
                else if (m_hold > 0) m_hold--;
                else m_wclk = 0;
            end
            p_evt = enable && (class_hi ? ((ser_data ^ ser_aux) != (pd ^ ps))
                                        : (ser_aux && !ps));
            p_bit = ser_data;
            pd = ser_data; ps = ser_aux;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison and word capture, away from the active edge.
    int last_word = -1;
    int words_seen = 0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(word_out == m_word[7:0], "R4 word_out vs model", word_out, m_word);
            check(word_valid == m_valid, "R5 word_valid vs model", word_valid, m_valid);
            check(word_clk == m_wclk, "R7 word_clk vs model", word_clk, m_wclk);
            if (word_valid) begin
                last_word = word_out;
                words_seen++;
            end
        end
    end

    task automatic drive(input bit d, input bit s);
        @(negedge clk);
        ser_data = d;
        ser_aux  = s;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(ser_data, ser_aux);
    endtask

    task automatic strobe_bit(input bit b, input int hold);
        bit x;
        x = ~(ser_data ^ ser_aux);
        drive(b, b ^ x);
        for (int i = 1; i < hold; i++) drive(ser_data, ser_aux);
    endtask

    task automatic clock_bit(input bit b, input bit noisy);
        drive(~b, 1'b0);
        drive(b, 1'b1);
        if (noisy) begin
            drive(~b, 1'b1);
            drive(b, 1'b0);
        end
    endtask

    task automatic set_class(input bit c);
        @(negedge clk);
        class_hi = c;
    endtask

    task automatic expect_word(input int exp, input int new_words, input int seen0, input string tag);
        idle(3);
        check(words_seen - seen0 == new_words, {tag, " word count"}, words_seen - seen0, new_words);
        check(last_word == exp, {tag, " word value"}, last_word, exp);
    endtask

    initial begin : main
        int s0;
        int held;
        repeat (3) @(negedge clk);
        check(word_out == 8'h00 && !word_valid && !word_clk, "R1 reset state", word_out, 0);
        @(negedge clk);
        rst = 1'b0;
        enable = 1'b1;
        @(negedge clk);
        check(word_out == 8'h00 && !word_valid && !word_clk, "R1 after release", word_out, 0);

        // R2 strobe signalling, one cycle per bit, MSB first (R4)
        s0 = words_seen;
        for (int i = 7; i >= 0; i--) strobe_bit(8'hA5 >> i, 1);
        expect_word(8'hA5, 1, s0, "R2 strobe A5");

        // R2 strobe, bits held three cycles: steady lines add nothing
        s0 = words_seen;
        for (int i = 7; i >= 0; i--) strobe_bit(8'h3C >> i, 3);
        expect_word(8'h3C, 1, s0, "R2 strobe held 3C");

        // R6 word held while idle
        idle(6);
        check(word_out == 8'h3C, "R6 word held", word_out, 8'h3C);

        // Back-to-back words, R4 R5
        s0 = words_seen;
        for (int i = 7; i >= 0; i--) strobe_bit(8'hFF >> i, 1);
        for (int i = 7; i >= 0; i--) strobe_bit(8'h00 >> i, 1);
        expect_word(8'h00, 2, s0, "R5 back-to-back");

        // R3 clock signalling with data noise and falling edges
        set_class(1'b0);
        drive(ser_data, 1'b0);
        s0 = words_seen;
        for (int i = 7; i >= 0; i--) clock_bit(8'h96 >> i, 1'b1);
        expect_word(8'h96, 1, s0, "R3 clock 96");

        // R8 alignment discards a partial word
        set_class(1'b1);
        idle(2);
        s0 = words_seen;
        for (int i = 0; i < 3; i++) strobe_bit(1'b1, 1);
        idle(2);
        @(negedge clk); align = 1'b1;
        @(negedge clk); align = 1'b0;
        for (int i = 7; i >= 0; i--) strobe_bit(8'h5A >> i, 1);
        expect_word(8'h5A, 1, s0, "R8 align 5A");

        // R9 disable: cleared outputs, activity ignored
        for (int i = 0; i < 4; i++) strobe_bit(1'b0, 1);
        @(negedge clk); enable = 1'b0;
        s0 = words_seen;
        for (int i = 0; i < 12; i++) strobe_bit(i[0], 1);
        idle(2);
        check(words_seen == s0, "R9 no words while off", words_seen - s0, 0);
        check(word_out == 8'h00 && !word_clk, "R9 outputs cleared", word_out, 0);
        @(negedge clk); enable = 1'b1;
        idle(2);
        for (int i = 7; i >= 0; i--) strobe_bit(8'hE1 >> i, 1);
        expect_word(8'hE1, 1, s0, "R9 fresh word after re-enable");

        // R10 one word across a class change
        s0 = words_seen;
        for (int i = 7; i >= 4; i--) strobe_bit(8'hC3 >> i, 2);
        set_class(1'b0);
        drive(ser_data, 1'b0);
        for (int i = 3; i >= 0; i--) clock_bit(8'hC3 >> i, 1'b0);
        expect_word(8'hC3, 1, s0, "R10 mixed class C3");

        // R7 word clock width, counted directly
        set_class(1'b1);
        idle(2);
        for (int i = 7; i >= 0; i--) strobe_bit(8'h81 >> i, 1);
        held = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (word_clk) held++;
        end
        check(held == HOLD, "R7 word clock width", held, HOLD);

        idle(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule